// File: doc/BRIEF.md
# Power Switch Ramp Controller

This block is the digital control for the power switch of one switchable domain. A power sequencer raises a request. The controller then closes the switch slowly, so that inrush current stays small. It does this by stepping a multi-bit gate-drive code from zero towards full scale, one step every programmable number of clocks. The block does not wait a fixed time to decide that power-up is complete. It enables a clocked comparator that watches the domain's virtual supply against a threshold of about nine tenths of the supply. Two consecutive above-threshold samples set a held flag, and that flag is the acknowledge returned to the sequencer.

The comparator, its reference and the switch transistors are outside the block; the comparator appears only as a sampled result input. Two cases end the power-up without an acknowledge. If the ramp reaches full scale and the threshold is not seen within a programmable number of clocks, the block raises a fault and keeps the acknowledge low. Dropping the request turns the switch off on the next clock edge and clears the acknowledge and the fault. The reset input is asynchronous, forces the switch off, and overrides the request.

Top module: `pswRampCtl`

## Requirements
- R1: While rst is high, gateCode is 0 and ack, fault and cmpEn are all low, whatever req and cmpAbove do.
- R2: From the off state (gateCode 0, ack and fault low), a clock edge that samples req high makes gateCode 1 and cmpEn high after that edge.
- R3: While ramping, gateCode rises by exactly 1 every N clock edges, where N is stepDiv (a stepDiv of 0 acts as 1). The code never exceeds full scale, which is 15 for the 4-bit default.
- R4: cmpEn is high exactly while the ramp is running or the full-scale code is waiting for the threshold. It is low whenever ack or fault is high.
- R5: When two consecutive clock edges each sample cmpAbove high while cmpEn is high, ack is high after the second of those edges. On that same edge gateCode goes to full scale and cmpEn goes low.
- R6: Above-threshold samples that are not consecutive (for example high, low, high) never set ack.
- R7: After gateCode has reached full scale, if L more clock edges pass without an acknowledge, fault goes high after the L-th edge, where L is toLimit (a toLimit of 0 acts as 1). While fault is high, ack stays low and gateCode stays at full scale.
- R8: A clock edge that samples req low makes gateCode 0 and ack, fault and cmpEn low after that edge, from any state.
- R9: Once set, ack (and likewise fault) stays high while req stays high, regardless of cmpAbove.
- R10: If the edge that completes the second consecutive above-threshold sample is also the edge on which the timeout would expire, ack is set and fault stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high; forces the switch off |
| req | input | 1 | Power-on request from the sequencer |
| cmpAbove | input | 1 | Sampled comparator result: virtual supply above threshold |
| stepDiv | input | DIV_W | Clock edges per gate-code step (0 acts as 1) |
| toLimit | input | LIM_W | Clock edges allowed at full scale before a fault (0 acts as 1) |
| gateCode | output | CODE_W | Gate-drive code for the power switch |
| cmpEn | output | 1 | Comparator clock enable |
| ack | output | 1 | Power-good acknowledge to the sequencer |
| fault | output | 1 | Timeout fault: threshold not reached |

## Verification
A wrong step divider or code counter shows up on gateCode within one step period, as a code that runs early, runs late or skips a value. A corrupted sample history shows up on ack one edge after the comparator pattern: either an acknowledge on isolated pulses or a missing one after two highs in a row. A broken timeout counter, or a wrong priority between success and timeout, shows up as a fault exactly L edges after full scale in place of an acknowledge, or the reverse. A state that fails to clear when the request drops is visible on the very next edge, as a nonzero code or a lingering flag.

// File: rtl/pswCtlPkg.sv
package pswCtlPkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RAMP  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_ON    = 3'd3,
    ST_FAULT = 3'd4
  } pswState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;      // return everything to off
    logic start;      // first step of a ramp
    logic rampEn;     // advance divider / code
    logic sampleEn;   // comparator sample is meaningful
    logic toEn;       // count full-scale wait cycles
    logic setAck;     // set the power-good flag
    logic setFault;   // set the timeout flag
    logic forceFull;  // drive code to full scale
  } pswCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic lastStep;   // this step reaches full scale
    logic toExpired;  // this wait cycle exhausts the limit
    logic twoHits;    // second consecutive above-threshold sample
  } pswStat_t;

endpackage

// File: rtl/pswCtlFsm.sv
module pswCtlFsm
  import pswCtlPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req,
  input  pswStat_t stat,
  output pswCmd_t  cmd,
  output logic     cmpEn
);

  pswState_t state, stateNxt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_OFF;
    else     state <= stateNxt;
  end

  assign cmpEn = (state == ST_RAMP) || (state == ST_WAIT);

  always_comb begin
    stateNxt = state;
    cmd      = '0;
    cmd.sampleEn = cmpEn;
    unique case (state)
      ST_OFF: begin
        if (req) begin
          cmd.start = 1'b1;
          stateNxt  = ST_RAMP;
        end else begin
          cmd.clear = 1'b1;
        end
      end
      ST_RAMP: begin
        if (!req) begin
          cmd.clear = 1'b1;
          stateNxt  = ST_OFF;
        end else if (stat.twoHits) begin
          cmd.setAck    = 1'b1;
          cmd.forceFull = 1'b1;
          stateNxt      = ST_ON;
        end else begin
          cmd.rampEn = 1'b1;
          if (stat.lastStep) stateNxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!req) begin
          cmd.clear = 1'b1;
          stateNxt  = ST_OFF;
        end else if (stat.twoHits) begin
          cmd.setAck    = 1'b1;
          cmd.forceFull = 1'b1;
          stateNxt      = ST_ON;
        end else begin
          cmd.toEn = 1'b1;
          if (stat.toExpired) begin
            cmd.setFault = 1'b1;
            stateNxt     = ST_FAULT;
          end
        end
      end
      ST_ON, ST_FAULT: begin
        if (!req) begin
          cmd.clear = 1'b1;
          stateNxt  = ST_OFF;
        end
      end
      default: begin
        cmd.clear = 1'b1;
        stateNxt  = ST_OFF;
      end
    endcase
  end

endmodule

// File: rtl/pswCtlPath.sv
module pswCtlPath
  import pswCtlPkg::*;
#(
  parameter int CODE_W = 4,
  parameter int DIV_W  = 8,
  parameter int LIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmpAbove,
  input  logic [DIV_W-1:0]  stepDiv,
  input  logic [LIM_W-1:0]  toLimit,
  input  pswCmd_t           cmd,
  output pswStat_t          stat,
  output logic [CODE_W-1:0] gateCode,
  output logic              ackFlag,
  output logic              faultFlag
);

  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_LAST = CODE_MAX - 1'b1;
  localparam logic [CODE_W-1:0] CODE_ONE  = {{(CODE_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divEnd;
  logic [LIM_W-1:0] toCnt;
  logic [LIM_W:0]   toNext;
  logic [LIM_W:0]   toEnd;
  logic             prevAbove;
  logic             divDone;

  // a zero divider or limit behaves as one
  assign divEnd  = (stepDiv == '0) ? '0 : stepDiv - 1'b1;
  assign divDone = (divCnt >= divEnd);
  assign toNext  = {1'b0, toCnt} + 1'b1;
  assign toEnd   = (toLimit == '0) ? {{LIM_W{1'b0}}, 1'b1} : {1'b0, toLimit};

  assign stat.lastStep  = divDone && (gateCode == CODE_LAST);
  assign stat.toExpired = (toNext >= toEnd);
  assign stat.twoHits   = cmd.sampleEn && cmpAbove && prevAbove;

  // gate-drive code and step divider
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      gateCode <= '0;
      divCnt   <= '0;
    end else if (cmd.clear) begin
      gateCode <= '0;
      divCnt   <= '0;
    end else if (cmd.start) begin
      gateCode <= CODE_ONE;
      divCnt   <= '0;
    end else if (cmd.forceFull) begin
      gateCode <= CODE_MAX;
    end else if (cmd.rampEn) begin
      if (divDone) begin
        divCnt <= '0;
        if (gateCode != CODE_MAX) gateCode <= gateCode + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // full-scale wait counter
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                       toCnt <= '0;
    else if (cmd.clear || cmd.start) toCnt <= '0;
    else if (cmd.toEn && !stat.toExpired) toCnt <= toCnt + 1'b1;
  end

  // comparator sample history
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                         prevAbove <= 1'b0;
    else if (cmd.clear || cmd.start) prevAbove <= 1'b0;
    else if (cmd.sampleEn)           prevAbove <= cmpAbove;
  end

  // set/reset result flags
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ackFlag   <= 1'b0;
      faultFlag <= 1'b0;
    end else if (cmd.clear) begin
      ackFlag   <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      if (cmd.setAck)   ackFlag   <= 1'b1;
      if (cmd.setFault) faultFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/pswRampCtl.sv
module pswRampCtl
  import pswCtlPkg::*;
#(
  parameter int CODE_W = 4,
  parameter int DIV_W  = 8,
  parameter int LIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              cmpAbove,
  input  logic [DIV_W-1:0]  stepDiv,
  input  logic [LIM_W-1:0]  toLimit,
  output logic [CODE_W-1:0] gateCode,
  output logic              cmpEn,
  output logic              ack,
  output logic              fault
);

  pswCmd_t  cmd;
  pswStat_t stat;

  pswCtlFsm uFsm (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .stat  (stat),
    .cmd   (cmd),
    .cmpEn (cmpEn)
  );

  pswCtlPath #(
    .CODE_W (CODE_W),
    .DIV_W  (DIV_W),
    .LIM_W  (LIM_W)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .cmpAbove  (cmpAbove),
    .stepDiv   (stepDiv),
    .toLimit   (toLimit),
    .cmd       (cmd),
    .stat      (stat),
    .gateCode  (gateCode),
    .ackFlag   (ack),
    .faultFlag (fault)
  );

endmodule

// File: rtl/pswRampCtlChk.sv
module pswRampCtlChk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              cmpAbove,
  input logic [CODE_W-1:0] gateCode,
  input logic              cmpEn,
  input logic              ack,
  input logic              fault
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  p_reset_off_r1: assert property (@(posedge clk)
    rst |-> (gateCode == '0 && !ack && !fault && !cmpEn));

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (gateCode == '0 && !ack && !fault && req) |=> (gateCode == 1 && cmpEn));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cmpEn && req && !cmpAbove) |=>
      ({1'b0, gateCode} >= {1'b0, $past(gateCode)} &&
       {1'b0, gateCode} <= {1'b0, $past(gateCode)} + 1'b1));

  p_en_excl_r4: assert property (@(posedge clk) disable iff (rst)
    cmpEn |-> (!ack && !fault && gateCode != '0));

  p_two_hits_r5: assert property (@(posedge clk) disable iff (rst)
    (cmpEn && req && cmpAbove && $past(cmpEn && cmpAbove)) |=>
      (ack && gateCode == CODE_MAX && !cmpEn));

  p_ack_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> ($past(cmpAbove) && $past(cmpAbove, 2)));

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!ack && gateCode == CODE_MAX && !cmpEn));

  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !req |=> (gateCode == '0 && !ack && !fault && !cmpEn));

  p_ack_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> ack);

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (fault && req) |=> fault);

endmodule

bind pswRampCtl pswRampCtlChk #(.CODE_W(CODE_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .cmpAbove (cmpAbove),
  .gateCode (gateCode),
  .cmpEn    (cmpEn),
  .ack      (ack),
  .fault    (fault)
);

// File: tb/tb_pswRampCtl.sv
module tb_pswRampCtl;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 4;
  localparam int DIV_W  = 8;
  localparam int LIM_W  = 12;
  localparam int CODE_MAX = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req = 1'b0;
  logic              cmpAbove = 1'b0;
  logic [DIV_W-1:0]  stepDiv = 8'd1;
  logic [LIM_W-1:0]  toLimit = 12'd4;
  logic [CODE_W-1:0] gateCode;
  logic              cmpEn, ack, fault;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  pswRampCtl #(.CODE_W(CODE_W), .DIV_W(DIV_W), .LIM_W(LIM_W)) dut (
    .clk(clk), .rst(rst), .req(req), .cmpAbove(cmpAbove),
    .stepDiv(stepDiv), .toLimit(toLimit),
    .gateCode(gateCode), .cmpEn(cmpEn), .ack(ack), .fault(fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  typedef enum int {M_OFF, M_RAMP, M_WAIT, M_ON, M_FAULT} mState_t;
  mState_t mSt = M_OFF;
  int mCode = 0, mDiv = 0, mTo = 0;
  bit mPrev = 0, mAck = 0, mFault = 0;

  function automatic int effN(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic mClear();
    mSt = M_OFF; mCode = 0; mDiv = 0; mTo = 0;
    mPrev = 0; mAck = 0; mFault = 0;
  endtask

  always @(posedge clk or posedge rst) begin
    if (rst) mClear();
    else begin
      case (mSt)
        M_OFF: if (req) begin
          mSt = M_RAMP; mCode = 1; mDiv = 0; mTo = 0; mPrev = 0;
        end
        M_RAMP, M_WAIT: begin
          if (!req) mClear();
          else if (cmpAbove && mPrev) begin
            mAck = 1; mCode = CODE_MAX; mSt = M_ON;
          end else begin
            mPrev = cmpAbove;
            if (mSt == M_RAMP) begin
              if (mDiv >= effN(int'(stepDiv)) - 1) begin
                mDiv = 0;
                mCode++;
                if (mCode == CODE_MAX) begin mSt = M_WAIT; mTo = 0; end
              end else mDiv++;
            end else begin
              if (mTo + 1 >= effN(int'(toLimit))) begin
                mFault = 1; mSt = M_FAULT;
              end else mTo++;
            end
          end
        end
        default: if (!req) mClear();
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelCmp();
    bit mEn;
    mEn = (mSt == M_RAMP) || (mSt == M_WAIT);
    chk("R3 gateCode vs model", int'(gateCode), mCode);
    chk("R4 cmpEn vs model", int'(cmpEn), int'(mEn));
    chk("R5 ack vs model", int'(ack), int'(mAck));
    chk("R7 fault vs model", int'(fault), int'(mFault));
  endtask

  // n rising edges, then settle to the falling edge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      modelCmp();
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset overrides request
    req = 1'b1; cmpAbove = 1'b1;
    tick(3);
    chk("R1 code in reset", int'(gateCode), 0);
    chk("R1 cmpEn in reset", int'(cmpEn), 0);
    chk("R1 ack in reset", int'(ack), 0);
    req = 1'b0; cmpAbove = 1'b0;
    rst = 1'b0;
    tick(2);

    // R2/R3/R7: slow ramp, comparator never trips
    stepDiv = 8'd3; toLimit = 12'd5;
    req = 1'b1;
    tick(1);
    chk("R2 first step code", int'(gateCode), 1);
    chk("R2 cmpEn on", int'(cmpEn), 1);
    tick(2);
    chk("R3 code before step", int'(gateCode), 1);
    tick(1);
    chk("R3 code after N edges", int'(gateCode), 2);
    tick(39);
    chk("R3 code reaches full", int'(gateCode), CODE_MAX);
    chk("R4 cmpEn while waiting", int'(cmpEn), 1);
    tick(4);
    chk("R7 no fault before limit", int'(fault), 0);
    tick(1);
    chk("R7 fault after limit", int'(fault), 1);
    chk("R7 ack low on fault", int'(ack), 0);
    chk("R4 cmpEn low on fault", int'(cmpEn), 0);
    cmpAbove = 1'b1;
    tick(3);
    chk("R9 fault held", int'(fault), 1);
    chk("R7 code held full", int'(gateCode), CODE_MAX);

    // R8: request drop
    req = 1'b0;
    tick(1);
    chk("R8 code off", int'(gateCode), 0);
    chk("R8 fault cleared", int'(fault), 0);
    chk("R8 cmpEn off", int'(cmpEn), 0);

    // R6 then R5 then R9
    cmpAbove = 1'b0; stepDiv = 8'd0; toLimit = 12'd100;
    req = 1'b1;
    tick(1);
    for (int i = 0; i < 6; i++) begin
      cmpAbove = (i % 2 == 0);
      tick(1);
    end
    chk("R6 isolated pulses no ack", int'(ack), 0);
    cmpAbove = 1'b1;
    tick(1);
    chk("R5 one high not enough", int'(ack), 0);
    tick(1);
    chk("R5 ack after two highs", int'(ack), 1);
    chk("R5 code forced full", int'(gateCode), CODE_MAX);
    chk("R5 cmpEn off", int'(cmpEn), 0);
    cmpAbove = 1'b0;
    tick(5);
    chk("R9 ack held", int'(ack), 1);
    req = 1'b0;
    tick(1);
    chk("R8 ack cleared", int'(ack), 0);

    // R10: success on the timeout edge
    stepDiv = 8'd1; toLimit = 12'd1;
    req = 1'b1;
    tick(14);
    cmpAbove = 1'b1;
    tick(2);
    chk("R10 ack wins", int'(ack), 1);
    chk("R10 no fault", int'(fault), 0);
    req = 1'b0; cmpAbove = 1'b0;
    tick(1);

    // R1: async reset mid-ramp
    req = 1'b1;
    tick(4);
    #1 rst = 1'b1;
    #1 chk("R1 async reset code", int'(gateCode), 0);
    @(negedge clk);
    rst = 1'b0;
    tick(1);

    // random episodes against the model
    void'($urandom(32'h5eed1234));
    for (int ep = 0; ep < 120; ep++) begin
      stepDiv  = DIV_W'($urandom_range(0, 3));
      toLimit  = LIM_W'($urandom_range(0, 12));
      for (int c = 0; c < 60; c++) begin
        req      = ($urandom_range(0, 29) != 0);
        cmpAbove = ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 199) == 0) rst = 1'b1;
        tick(1);
        rst = 1'b0;
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule